// File: doc/BRIEF.md
# FP8 Widening Indexed Multiply-Accumulate

This block is a vector datapath that multiplies 8-bit floating-point values and adds each product into a half-precision accumulator with one rounding. Of the first FP8 source only the even byte lanes are used. Each even byte meets one FP8 multiplier taken from the second source. The index picks that multiplier afresh inside every 128-bit slice, and the slice's result lanes share it. Each product is added to the FP16 lane that lines up with the byte pair, and the sum is rounded once to FP16 with round-to-nearest-even.

Two control bits set the encoding of each FP8 source on its own: E5M2, with bias 15, infinities and NaNs, or E4M3, with bias 7, no infinities and a single NaN pattern per sign. The vector width is a parameter (128 to 2048 bits). Operands enter under `valid_in`. Results come out two cycles later with `valid_out`, and a new operand set can be taken every cycle.

Top module: `fp8_mla_bottom`

## Requirements
- R1: For result lane i, `res_vec[16i+15:16i]` equals the RNE FP16 rounding of the exact value `acc_vec[16i+15:16i] + a_vec[16i+7:16i] * b`. The odd bytes of `a_vec` have no effect.
- R2: The multiplier `b` for lane i is byte `idx` (0..15) of the 128-bit slice of `b_vec` that holds lane i, that is `b_vec[(i/8)*128 + idx*8 +: 8]`.
- R3: `fmt_a` sets the encoding of the `a_vec` bytes and `fmt_b` sets the encoding of `b`, each on its own. 0 means E5M2 (sign, 5 exponent bits, 2 mantissa bits, bias 15). 1 means E4M3 (sign, 4 exponent bits, 3 mantissa bits, bias 7).
- R4: In E4M3, only the low seven bits 0x7F are NaN. Exponent 1111 with a mantissa below 7 is a normal number (0x7E is 448), and no E4M3 code is infinite.
- R5: Any NaN operand, infinity times zero, or infinite product plus infinity of the opposite sign gives 0x7E00. No other NaN pattern ever appears on the output.
- R6: A finite result whose magnitude rounds past the FP16 maximum gives 0x7C00 or 0xFC00, following the sign of the exact sum. An infinite operand with no NaN condition gives an infinity with that operand's sign.
- R7: FP8 subnormal inputs are taken exactly. FP16 subnormal results are produced and not flushed (2^-15 gives 0x0200).
- R8: An exact zero sum is +0 when the product and the accumulator have opposite signs, and keeps their common sign otherwise.
- R9: `valid_out` equals `valid_in` from two clock edges earlier, and `res_vec` holds the result of that operand set. Operands are accepted on every cycle.
- R10: While `rst_n` is low, `valid_out` is 0 from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operand set valid |
| idx | input | 4 | Multiplier byte index within each 128-bit slice |
| fmt_a | input | 1 | Encoding of a_vec bytes: 0 E5M2, 1 E4M3 |
| fmt_b | input | 1 | Encoding of the multiplier: 0 E5M2, 1 E4M3 |
| a_vec | input | VLEN | FP8 multiplicand bytes (even bytes used) |
| b_vec | input | VLEN | FP8 bytes the multiplier is picked from |
| acc_vec | input | VLEN | FP16 accumulators |
| valid_out | output | 1 | Result valid |
| res_vec | output | VLEN | FP16 results |

## Verification
The hardest cases to reach are the exact boundaries of the single rounding. These include sums that land exactly halfway between two FP16 values, cancellation to an exact zero, and results that fall into the FP16 subnormal range or just past its maximum. Uniform random bytes almost never land on these points. Directed operand sets place them on purpose: a product of 2^-11 against accumulators 1.0 and 1+2^-10, equal and opposite values, 2^-14 times 0.5, and the largest E5M2 value squared. Random traffic with gaps, mixed encodings and indices covering both 128-bit slices is run as well.

// File: rtl/fp8_mla_bottom.sv
module fp8_mla_bottom #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_in,
  input  logic [3:0]      idx,
  input  logic            fmt_a,
  input  logic            fmt_b,
  input  logic [VLEN-1:0] a_vec,
  input  logic [VLEN-1:0] b_vec,
  input  logic [VLEN-1:0] acc_vec,
  output logic            valid_out,
  output logic [VLEN-1:0] res_vec
);
  localparam int LANES = VLEN / 16;
  localparam int LPS   = 8;
  localparam int W     = 66;

  // {nan, inf, significand[3:0], lsb exponent + 16}
  function automatic logic [10:0] dec8(input logic [7:0] x, input logic f);
    logic nan, inf;
    logic [3:0] sig;
    logic [4:0] sh;
    if (!f) begin
      nan = (&x[6:2]) & (|x[1:0]);
      inf = (&x[6:2]) & ~(|x[1:0]);
      sig = {1'b0, |x[6:2], x[1:0]};
      sh  = (|x[6:2] ? x[6:2] : 5'd1) - 5'd1;
    end else begin
      nan = &x[6:0];
      inf = 1'b0;
      sig = {|x[6:3], x[2:0]};
      sh  = {1'b0, (|x[6:3] ? x[6:3] : 4'd1)} + 5'd6;
    end
    return {nan, inf, sig, sh};
  endfunction

  function automatic logic [15:0] mac(input logic [7:0] a, input logic [7:0] b,
                                      input logic fa, input logic fb, input logic [15:0] c);
    logic [10:0] da, db;
    logic za, zb, nc, ic, sp, sc, sg, g, st, up, nan;
    logic [W-1:0] pm, cm, m;
    logic [6:0] sa, fld;
    logic [11:0] q;
    int p;
    da = dec8(a, fa);
    db = dec8(b, fb);
    za = da[8:5] == 4'd0;
    zb = db[8:5] == 4'd0;
    nc = (&c[14:10]) & (|c[9:0]);
    ic = (&c[14:10]) & ~(|c[9:0]);
    sp = a[7] ^ b[7];
    sc = c[15];
    pm = (W'(da[8:5]) * W'(db[8:5])) << (6'(da[4:0]) + 6'(db[4:0]));
    cm = W'({|c[14:10], c[9:0]}) << (6'(|c[14:10] ? c[14:10] : 5'd1) + 6'd7);
    if (sp == sc) begin m = pm + cm; sg = sp; end
    else if (pm >= cm) begin m = pm - cm; sg = sp; end
    else begin m = cm - pm; sg = sc; end
    if (m == '0) sg = sp & sc;
    p = 0;
    for (int k = 0; k < W; k++) if (m[k]) p = k;
    sa = (p > 18) ? 7'(p - 10) : 7'd8;
    q  = 12'(m >> sa);
    g  = m[sa - 7'd1];
    st = |(m & ((W'(1) << (sa - 7'd1)) - W'(1)));
    up = g & (st | q[0]);
    q  = q + 12'(up);
    if (q[11]) begin q = q >> 1; sa = sa + 7'd1; end
    fld = q[10] ? sa - 7'd7 : 7'd0;
    nan = da[10] | db[10] | nc | (da[9] & zb) | (db[9] & za)
        | ((da[9] | db[9]) & ic & (sp != sc));
    if (nan) return 16'h7E00;
    if (da[9] | db[9]) return {sp, 15'h7C00};
    if (ic) return {sc, 15'h7C00};
    if (fld >= 7'd31) return {sg, 15'h7C00};
    return {sg, fld[4:0], q[9:0]};
  endfunction

  logic            v1, fa1, fb1;
  logic [3:0]      idx1;
  logic [VLEN-1:0] a1, b1, c1, nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      valid_out <= 1'b0;
    end else begin
      v1        <= valid_in;
      valid_out <= v1;
    end
    if (valid_in) begin
      a1 <= a_vec; b1 <= b_vec; c1 <= acc_vec;
      idx1 <= idx; fa1 <= fmt_a; fb1 <= fmt_b;
    end
    if (v1) res_vec <= nxt;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [127:0] seg;
    logic [7:0]   bsel;
    assign seg  = b1[(i / LPS) * 128 +: 128];
    assign bsel = seg[idx1 * 8 +: 8];
    assign nxt[16*i +: 16] = mac(a1[16*i +: 8], bsel, fa1, fb1, c1[16*i +: 16]);
  end
endmodule

// File: rtl/fp8_mla_bottom_chk.sv
module fp8_mla_bottom_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_in,
  input logic [3:0]   idx,
  input logic         fmt_a,
  input logic         fmt_b,
  input logic [7:0]   a_lo,
  input logic [127:0] b_lo,
  input logic [15:0]  acc_lo,
  input logic         valid_out,
  input logic [15:0]  res_lo
);
  logic [1:0] cnt;
  always_ff @(posedge clk)
    if (!rst_n) cnt <= 2'd0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;

  logic [7:0] bsel0;
  logic b_fin, c_fin_nz;
  assign bsel0    = b_lo[idx * 8 +: 8];
  assign b_fin    = fmt_b ? (bsel0[6:0] != 7'h7F) : (bsel0[6:2] != 5'h1F);
  assign c_fin_nz = (acc_lo[14:10] != 5'h1F) && (acc_lo[14:0] != 15'd0);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt >= 2'd2 |-> valid_out == $past(valid_in, 2));

  p_reset_clear_r10: assert property (@(posedge clk) !rst_n |=> !valid_out);

  p_e4m3_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 2'd2 && valid_out && $past(fmt_a && a_lo[6:0] == 7'h7F, 2)) |-> res_lo == 16'h7E00);

  p_canon_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_out && res_lo[14:10] == 5'h1F && res_lo[9:0] != 10'd0) |-> res_lo == 16'h7E00);

  p_zero_prod_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 2'd2 && valid_out && $past(a_lo[6:0] == 7'd0 && b_fin && c_fin_nz, 2))
      |-> res_lo == $past(acc_lo, 2));
endmodule

bind fp8_mla_bottom fp8_mla_bottom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .idx(idx), .fmt_a(fmt_a), .fmt_b(fmt_b),
  .a_lo(a_vec[7:0]), .b_lo(b_vec[127:0]), .acc_lo(acc_vec[15:0]),
  .valid_out(valid_out), .res_lo(res_vec[15:0])
);

// File: tb/test_fp8_mla_bottom.sv
module test_fp8_mla_bottom;
  localparam int VLEN  = 256;
  localparam int LANES = VLEN / 16;

  logic clk = 1'b0, rst_n = 1'b0, valid_in = 1'b0, fmt_a = 1'b0, fmt_b = 1'b0;
  logic [3:0] idx = '0;
  logic [VLEN-1:0] a_vec = '0, b_vec = '0, acc_vec = '0;
  logic valid_out;
  logic [VLEN-1:0] res_vec;

  fp8_mla_bottom #(.VLEN(VLEN)) i_fp8_mla_bottom (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit h1 = 0, h2 = 0, done = 0;
  logic [VLEN-1:0] qexp[$];
  string qtag[$];

  function automatic real dec8r(input logic [7:0] x, input bit f, output bit nan, output bit inf);
    int e, m;
    real r;
    if (!f) begin
      e = x[6:2]; m = x[1:0];
      nan = (e == 31 && m != 0); inf = (e == 31 && m == 0);
      r = (e == 0) ? m * 2.0 ** (-16) : (1.0 + m / 4.0) * 2.0 ** (e - 15);
    end else begin
      e = x[6:3]; m = x[2:0];
      nan = (e == 15 && m == 7); inf = 0;
      r = (e == 0) ? m * 2.0 ** (-9) : (1.0 + m / 8.0) * 2.0 ** (e - 7);
    end
    return r;
  endfunction

  function automatic real dec16r(input logic [15:0] x, output bit nan, output bit inf);
    int e, m;
    e = x[14:10]; m = x[9:0];
    nan = (e == 31 && m != 0); inf = (e == 31 && m == 0);
    return (e == 0) ? m * 2.0 ** (-24) : (1.0 + m / 1024.0) * 2.0 ** (e - 15);
  endfunction

  function automatic logic [15:0] rnd16(input real a, input bit s);
    int e, ri;
    real ulp, q, r, fr;
    e = -14;
    while (e < 16 && a >= 2.0 ** (e + 1)) e++;
    if (e > 15) return {s, 15'h7C00};
    ulp = 2.0 ** (e - 10);
    q = a / ulp;
    r = $floor(q);
    fr = q - r;
    ri = $rtoi(r);
    if (fr > 0.5 || (fr == 0.5 && (ri % 2) == 1)) ri++;
    if (ri >= 2048) begin ri = ri / 2; e++; end
    if (e > 15) return {s, 15'h7C00};
    if (ri >= 1024) return {s, 5'(e + 15), 10'(ri)};
    return {s, 5'd0, 10'(ri)};
  endfunction

  function automatic logic [15:0] ref_lane(input logic [7:0] a, input logic [7:0] b,
                                           input bit fa, input bit fb, input logic [15:0] c);
    bit na, ia, nb, ib, nc, ic, sp, sc;
    real va, vb, vc, sum;
    va = dec8r(a, fa, na, ia);
    vb = dec8r(b, fb, nb, ib);
    vc = dec16r(c, nc, ic);
    sp = a[7] ^ b[7]; sc = c[15];
    if (na || nb || nc) return 16'h7E00;
    if ((ia && vb == 0.0) || (ib && va == 0.0)) return 16'h7E00;
    if ((ia || ib) && ic && sp != sc) return 16'h7E00;
    if (ia || ib) return {sp, 15'h7C00};
    if (ic) return {sc, 15'h7C00};
    sum = (sp ? -(va * vb) : va * vb) + (sc ? -vc : vc);
    if (sum == 0.0) return {sp & sc, 15'd0};
    return rnd16(sum < 0.0 ? -sum : sum, sum < 0.0);
  endfunction

  function automatic logic [VLEN-1:0] ref_vec(input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                                              input logic [VLEN-1:0] c, input logic [3:0] ix,
                                              input bit fa, input bit fb);
    logic [VLEN-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[16*i +: 16] = ref_lane(a[16*i +: 8], b[(i/8)*128 + ix*8 +: 8], fa, fb, c[16*i +: 16]);
    return r;
  endfunction

  task automatic step(input bit v, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                      input logic [VLEN-1:0] c, input logic [3:0] ix, input bit fa, input bit fb,
                      input string tag);
    logic [VLEN-1:0] e;
    string t;
    @(negedge clk);
    checks++;
    if (valid_out !== h2) begin
      fails++; $display("FAIL R9 valid_out=%b expected %b", valid_out, h2);
    end
    if (valid_out === 1'b1 && qexp.size() > 0) begin
      e = qexp.pop_front(); t = qtag.pop_front();
      for (int i = 0; i < LANES; i++) begin
        checks++;
        if (res_vec[16*i +: 16] !== e[16*i +: 16]) begin
          fails++;
          $display("FAIL %s lane %0d: got %h expected %h", t, i, res_vec[16*i +: 16], e[16*i +: 16]);
        end
      end
    end
    h2 = h1; h1 = v;
    valid_in = v; a_vec = a; b_vec = b; acc_vec = c; idx = ix; fmt_a = fa; fmt_b = fb;
    if (v) begin qexp.push_back(ref_vec(a, b, c, ix, fa, fb)); qtag.push_back(tag); end
  endtask

  task automatic dir(input logic [7:0] a8, input logic [7:0] b8, input logic [15:0] c16,
                     input bit fa, input bit fb, input string tag);
    step(1'b1, {LANES{8'hA5, a8}}, {(VLEN/8){b8}}, {LANES{c16}}, 4'(checks), fa, fb, tag);
  endtask

  function automatic logic [VLEN-1:0] rvec();
    logic [VLEN-1:0] r;
    for (int i = 0; i < VLEN / 32; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    checks++;
    if (valid_out !== 1'b0) begin fails++; $display("FAIL R10 valid_out=%b expected 0", valid_out); end
    rst_n = 1'b1;
    dir(8'h3C, 8'h40, 16'h3C00, 0, 0, "R1");
    dir(8'h10, 8'h3C, 16'h3C00, 0, 0, "R1");
    dir(8'h10, 8'h3C, 16'h3C01, 0, 0, "R1");
    dir(8'h7E, 8'h38, 16'h0000, 1, 1, "R3");
    dir(8'h7E, 8'h38, 16'h0000, 1, 0, "R3");
    dir(8'h38, 8'h7E, 16'h0000, 0, 1, "R3");
    dir(8'h7F, 8'h3C, 16'h3C00, 1, 0, "R4");
    dir(8'h78, 8'h38, 16'h0000, 1, 1, "R4");
    dir(8'h7C, 8'h00, 16'h0000, 0, 0, "R5");
    dir(8'h3C, 8'h3C, 16'h7C01, 0, 0, "R5");
    dir(8'h7C, 8'h3C, 16'hFC00, 0, 0, "R5");
    dir(8'h7B, 8'h7B, 16'h0000, 0, 0, "R6");
    dir(8'hFB, 8'h7B, 16'h0000, 0, 0, "R6");
    dir(8'h7E, 8'h7E, 16'h3C00, 1, 1, "R6");
    dir(8'h04, 8'h38, 16'h0000, 0, 0, "R7");
    dir(8'h01, 8'h3C, 16'h8001, 0, 0, "R7");
    dir(8'h01, 8'h01, 16'h0000, 1, 1, "R7");
    dir(8'h3C, 8'h3C, 16'hBC00, 0, 0, "R8");
    dir(8'h80, 8'h3C, 16'h8000, 0, 0, "R8");
    dir(8'h80, 8'h3C, 16'h0000, 0, 0, "R8");
    for (int n = 0; n < 600; n++)
      step(($urandom % 4) != 0, rvec(), rvec(), rvec(), 4'($urandom), 1'($urandom), 1'($urandom),
           (n % 2) ? "R2" : "R1");
    repeat (4) step(1'b0, rvec(), rvec(), rvec(), 4'd0, 1'b0, 1'b0, "R9");
    checks++;
    if (qexp.size() != 0) begin fails++; $display("FAIL R9 pending=%0d expected 0", qexp.size()); end
    rst_n = 1'b0;
    step(1'b1, rvec(), rvec(), rvec(), 4'd0, 1'b0, 1'b0, "R10");
    @(negedge clk);
    checks++;
    if (valid_out !== 1'b0) begin fails++; $display("FAIL R10 valid_out=%b expected 0", valid_out); end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule